// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital sequencer of a 12-bit successive-approximation analog-to-digital converter. Two active-low control lines, a chip select and a read/convert select, are brought into the clock domain and combined. When both lines stay low long enough, a conversion starts. The controller then drives a trial word to the capacitor DAC one bit at a time, starting at the MSB. After each trial it takes one comparator bit back and decides whether to keep that bit. When the last bit is settled, the result goes into an output register in two's complement coding.

A low level on `busy_n` marks a conversion in progress, and commands that arrive during that time have no effect. The parallel data bus is modelled as a data vector plus an output-enable. It is driven only in read mode, which means chip select low, read/convert high and no conversion running. While `busy_n` is high the trial word rests at zero, so the analog front end can follow its input again.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A conversion starts, with `busy_n` falling, once the OR of the synchronized `cs_n` and `rd_conv` has been low for `MIN_LOW` consecutive clocks. Either line may be the one that falls last. With the defaults, `busy_n` is low in the fourth clock after the command is applied.
- R2: A low on the combined control that lasts fewer than `MIN_LOW` synchronized clocks starts nothing.
- R3: `busy_n` stays low for exactly `W` clocks per conversion. It rises only in the cycle in which the new result is already in the output register. After reset, `busy_n` is 1.
- R4: Start commands that arrive while `busy_n` is low are ignored. A combined control held low across the end of a conversion does not start another one.
- R5: `data_oe` is 1 only when the synchronized `rd_conv` is 1, the synchronized `cs_n` is 0 and no conversion is running. Every other combination gives 0.
- R6: While `data_oe` is 0, `data_out` is all zeros. While `data_oe` is 1, `data_out` carries the output register.
- R7: The result is two's complement with the sign on bit `W-1`. For W=12 and a comparator threshold code V given in offset binary, the result is V with bit 11 inverted: 0xFFF gives 0x7FF, 0x800 gives 0x000, 0x7FF gives 0xFFF and 0x000 gives 0x800.
- R8: Trials run from the MSB down to the LSB, one bit per clock. A trial bit is kept when `cmp_in` is 1, meaning the input is at or above the trial level.
- R9: The output register holds the last result until the next conversion completes. It is updated even when the bus is not enabled.
- R10: `dac_word` is zero whenever no conversion is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_conv | input | 1 | Read/convert select: 1 read, 0 convert; asynchronous |
| cmp_in | input | 1 | Comparator bit, 1 when input is at or above the trial level |
| dac_word | output | W | Trial word to the capacitor DAC |
| busy_n | output | 1 | Low while a conversion runs |
| data_out | output | W | Parallel result, zero when not enabled |
| data_oe | output | 1 | Output enable of the parallel bus |

## Verification
The bench builds the block with W=12 and MIN_LOW=2. With these values the four coding corners (0x000, 0x7FF, 0x800, 0xFFF) can be reached. A single-clock glitch is shorter than the start threshold, so it can be used to test rejection. A 12-clock conversion leaves room for a full second command to be placed inside it. A behavioural comparator compares the trial word with a chosen code, so every SAR decision can be followed, and both orders of the start lines are mixed with random input codes.

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int W       = 12,
  parameter int MIN_LOW = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_conv,
  input  logic         cmp_in,
  output logic [W-1:0] dac_word,
  output logic         busy_n,
  output logic [W-1:0] data_out,
  output logic         data_oe
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic [1:0]    cs_sy, rc_sy;
  logic [CW-1:0] low_cnt;
  logic          conv;
  logic [IW-1:0] idx;
  logic [W-1:0]  sar, result;

  wire cmd_low = ~(cs_sy[1] | rc_sy[1]);
  wire start   = ~conv & cmd_low & (low_cnt == CW'(MIN_LOW - 1));

  wire [W-1:0] bit_mask = W'(1) << idx;
  wire [W-1:0] trial    = sar | bit_mask;
  wire [W-1:0] sar_nx   = cmp_in ? trial : sar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= 2'b11;
      rc_sy <= 2'b11;
    end else begin
      cs_sy <= {cs_sy[0], cs_n};
      rc_sy <= {rc_sy[0], rd_conv};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        low_cnt <= '0;
    else if (!cmd_low)                 low_cnt <= '0;
    else if (low_cnt != CW'(MIN_LOW))  low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv   <= 1'b0;
      idx    <= '0;
      sar    <= '0;
      result <= '0;
    end else if (start) begin
      conv <= 1'b1;
      idx  <= IW'(W - 1);
      sar  <= '0;
    end else if (conv) begin
      sar <= sar_nx;
      if (idx == '0) begin
        conv   <= 1'b0;
        result <= {~sar_nx[W-1], sar_nx[W-2:0]};
      end else begin
        idx <= idx - 1'b1;
      end
    end
  end

  assign dac_word = conv ? trial : '0;
  assign busy_n   = ~conv;
  assign data_oe  = rc_sy[1] & ~cs_sy[1] & ~conv;
  assign data_out = data_oe ? result : '0;
endmodule

module sar_adc_ctrl_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] dac_word,
  input logic         busy_n,
  input logic [W-1:0] data_out,
  input logic         data_oe
);
  AST_OE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> busy_n); // R5
  AST_TRISTATE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0)); // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |=> !busy_n); // R3
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |=> busy_n); // R4
  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> (dac_word == (W'(1) << (W - 1)))); // R8
  AST_DAC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |-> (dac_word == '0)); // R10
  AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && $past(data_oe)) |-> $stable(data_out)); // R9
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_word(dac_word), .busy_n(busy_n),
  .data_out(data_out), .data_oe(data_oe)
);

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rd_conv = 1'b1;
  logic [W-1:0] vin = '0;
  logic [W-1:0] dac_word, data_out;
  logic busy_n, data_oe;
  wire cmp_in = (dac_word <= vin);

  int tests = 0, fails = 0, nconv = 0;
  logic prev_busy = 1'b1;

  sar_adc_ctrl #(.W(W), .MIN_LOW(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_conv(rd_conv), .cmp_in(cmp_in),
    .dac_word(dac_word), .busy_n(busy_n), .data_out(data_out), .data_oe(data_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    prev_busy <= busy_n;
    if (prev_busy && !busy_n) nconv <= nconv + 1;
  end

  function automatic logic [W-1:0] expect_code(input logic [W-1:0] v);
    return {~v[W-1], v[W-2:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && !busy_n; i++) @(negedge clk);
  endtask

  task automatic convert(input logic [W-1:0] v, input bit cs_last, input bit read_after);
    int n0;
    n0 = nconv;
    vin = v;
    if (cs_last) begin rd_conv = 1'b0; cs_n = 1'b1; cyc(3); cs_n = 1'b0; end
    else begin cs_n = 1'b0; rd_conv = 1'b1; cyc(3); rd_conv = 1'b0; end
    cyc(4);
    chk(busy_n == 1'b0, "R1", busy_n, 0);
    if (read_after) rd_conv = 1'b1;
    cyc(W - 1);
    chk(busy_n == 1'b0, "R3", busy_n, 0);
    cyc(1);
    chk(busy_n == 1'b1, "R3", busy_n, 1);
    cyc(3);
    chk(nconv == n0 + 1, "R4", nconv, n0 + 1);
    if (read_after) begin
      chk(data_oe == 1'b1, "R5", data_oe, 1);
      chk(data_out == expect_code(v), "R7 R8", data_out, expect_code(v));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    int n0;
    void'($urandom(32'h5eed));
    cyc(3);
    chk(busy_n == 1'b1, "R3", busy_n, 1);
    chk(data_oe == 1'b0 && data_out == '0, "R6", data_out, 0);
    chk(dac_word == '0, "R10", dac_word, 0);
    rst_n = 1'b1;
    cyc(3);

    convert(12'hFFF, 1'b0, 1'b1);
    convert(12'h800, 1'b1, 1'b1);
    convert(12'h7FF, 1'b0, 1'b1);
    convert(12'h000, 1'b1, 1'b1);
    chk(dac_word == '0, "R10", dac_word, 0);

    cs_n = 1'b1; cyc(3);
    chk(data_oe == 1'b0 && data_out == '0, "R5 R6", data_out, 0);
    rd_conv = 1'b0; cyc(3);
    chk(data_oe == 1'b0 && data_out == '0, "R5 R6", data_out, 0);
    rd_conv = 1'b1; cs_n = 1'b0; cyc(3);
    chk(data_out == 12'h800, "R9", data_out, 12'h800);

    n0 = nconv;
    rd_conv = 1'b0; cyc(1); rd_conv = 1'b1; cyc(10);
    chk(nconv == n0, "R2", nconv, n0);
    chk(data_out == 12'h800, "R2", data_out, 12'h800);

    n0 = nconv;
    vin = 12'h5A3;
    rd_conv = 1'b0; cyc(4);
    rd_conv = 1'b1; cyc(2); rd_conv = 1'b0; cyc(4);
    chk(busy_n == 1'b0, "R4", busy_n, 0);
    wait_idle();
    cyc(10);
    chk(nconv == n0 + 1, "R4", nconv, n0 + 1);
    chk(data_oe == 1'b0, "R5", data_oe, 0);
    rd_conv = 1'b1; cyc(3);
    chk(data_out == expect_code(12'h5A3), "R7", data_out, expect_code(12'h5A3));

    convert(12'h123, 1'b1, 1'b0);
    chk(data_oe == 1'b0, "R9", data_oe, 0);
    cs_n = 1'b1; rd_conv = 1'b1; cyc(2); cs_n = 1'b0; cyc(3);
    chk(data_out == expect_code(12'h123), "R9", data_out, expect_code(12'h123));

    for (int k = 0; k < 24; k++) begin
      v = W'($urandom);
      convert(v, k[0], 1'b1);
      chk(dac_word == '0, "R10", dac_word, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule